// File: doc/BRIEF.md
# Ring Signal Duty-Cycle Qualifier

This block decides whether a ringing voltage on a subscriber line is a genuine ring. An analog stage outside the block compares the attenuated line voltage against a fixed threshold. It delivers the result as one bit, synchronous to the block clock. The block feeds that bit into a saturating up/down integrator. While the bit is high, the count climbs on every pulse of a fast tick enable. While the bit is low, the count falls on every pulse of a slow tick enable, which runs at half the fast rate. The balance of the count therefore follows the duty cycle of the comparator, not the number of its edges.

The ring is declared valid when the count reaches an upper level. It is withdrawn only when the count falls back to a lower level, so short gaps between ring cycles do not toggle the result. The result is an active-low ring-detect output. It can drive a processor interrupt or request a full power-up. The power controller gates the whole qualifier with an enable. Dropping the enable clears the count and releases the output. With the default tick rates of 800 Hz and 400 Hz, the fastest qualification takes about 60 ms and the fastest withdrawal about 40 ms.

Top module: `ring_qualifier`

## Requirements
- R1: While reset is held, and in the cycles after its release before any tick is counted, `ring_det_n_o` is high and the count is 0.
- R2: With the enable high and the comparator high, each cycle in which `tick_up_i` is 1 raises the count by one. `tick_dn_i` has no effect while the comparator is high.
- R3: With the enable high and the comparator low, each cycle in which `tick_dn_i` is 1 lowers the count by one. `tick_up_i` has no effect while the comparator is low.
- R4: When the output is high and the registered count is at or above QUAL_LVL (default 48), `ring_det_n_o` goes low at the next clock edge.
- R5: Once low, `ring_det_n_o` stays low while the count is above DROP_LVL (default 32). It goes high at the next clock edge after the count is at or below DROP_LVL.
- R6: The count saturates: an up tick at 2**CNT_W-1 (default 63) leaves it unchanged, and a down tick at 0 leaves it unchanged.
- R7: While `analysis_en_i` is low, the count is cleared to 0 and `ring_det_n_o` is high from the next clock edge on. Ticks and the comparator have no effect.
- R8: In a cycle with neither tick active, the count keeps its value whatever the comparator does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_up_i | input | 1 | One-cycle enable at the fast (up-count) rate |
| tick_dn_i | input | 1 | One-cycle enable at the slow (down-count) rate |
| analysis_en_i | input | 1 | Ring analysis enable from power control; low clears the qualifier |
| cmp_i | input | 1 | Thresholded ring comparator bit, synchronous to clk |
| ring_det_n_o | output | 1 | Active-low ring-valid indication |

## Verification
On every cycle, the assertions check several rules:
- the count moves only in the direction the comparator allows, at most one step at a time;
- the count holds without a tick;
- the count is pinned at its ceiling;
- the enable clears the block;
- every output edge is preceded by a count on the correct side of its threshold.

Only the bench's scenarios can show the exact threshold values, because it observes the single output alone. They also show the width of the hysteresis band, that saturation at both ends preserves the exact count afterwards, and that the count after a disable starts from zero.

// File: rtl/ringq_pkg.sv
package ringq_pkg;

  // Direction chosen for the integrator in a given cycle
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_UP    = 2'd1,
    STEP_DOWN  = 2'd2,
    STEP_CLEAR = 2'd3
  } step_e;

endpackage

// File: rtl/ringq_rst_sync.sv
module ringq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/ringq_step_sel.sv
module ringq_step_sel
  import ringq_pkg::*;
(
  input  logic  enable,
  input  logic  cmp,
  input  logic  tick_up,
  input  logic  tick_dn,
  output step_e step
);

  // The comparator level picks which tick is relevant; the other is ignored
  always_comb begin
    step = STEP_HOLD;
    if (!enable) begin
      step = STEP_CLEAR;
    end else if (cmp) begin
      if (tick_up) step = STEP_UP;
    end else begin
      if (tick_dn) step = STEP_DOWN;
    end
  end

endmodule

// File: rtl/ringq_integrator.sv
module ringq_integrator
  import ringq_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  step_e            step,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (step)
      STEP_CLEAR: begin
        cnt_d  = '0;
        cnt_en = (cnt_q != '0);
      end
      STEP_UP: begin
        cnt_d  = cnt_q + CNT_ONE;
        cnt_en = (cnt_q != CNT_TOP);
      end
      STEP_DOWN: begin
        cnt_d  = cnt_q - CNT_ONE;
        cnt_en = (cnt_q != '0);
      end
      default: begin
        cnt_d  = cnt_q;
        cnt_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/ringq_hysteresis.sv
module ringq_hysteresis #(
  parameter int CNT_W    = 6,
  parameter int QUAL_LVL = 48,
  parameter int DROP_LVL = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [CNT_W-1:0] cnt,
  output logic             valid_o
);

  localparam logic [CNT_W-1:0] QUAL_C = CNT_W'(QUAL_LVL);
  localparam logic [CNT_W-1:0] DROP_C = CNT_W'(DROP_LVL);

  logic valid_q;
  logic valid_d;

  always_comb begin
    valid_d = valid_q;
    if (clear) begin
      valid_d = 1'b0;
    end else if (!valid_q && (cnt >= QUAL_C)) begin
      valid_d = 1'b1;
    end else if (valid_q && (cnt <= DROP_C)) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_d != valid_q) begin
      valid_q <= valid_d;
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/ring_qualifier.sv
module ring_qualifier #(
  parameter int CNT_W    = 6,
  parameter int QUAL_LVL = 48,
  parameter int DROP_LVL = 32,
  parameter int RST_SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_up_i,
  input  logic tick_dn_i,
  input  logic analysis_en_i,
  input  logic cmp_i,
  output logic ring_det_n_o
);

  import ringq_pkg::*;

  logic             rst_sync_n;
  step_e            step;
  logic [CNT_W-1:0] cnt_q;
  logic             valid;

  ringq_rst_sync #(
    .STAGES (RST_SYNC)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ringq_step_sel u_step_sel (
    .enable  (analysis_en_i),
    .cmp     (cmp_i),
    .tick_up (tick_up_i),
    .tick_dn (tick_dn_i),
    .step    (step)
  );

  ringq_integrator #(
    .CNT_W (CNT_W)
  ) u_integrator (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (step),
    .cnt_o (cnt_q)
  );

  ringq_hysteresis #(
    .CNT_W    (CNT_W),
    .QUAL_LVL (QUAL_LVL),
    .DROP_LVL (DROP_LVL)
  ) u_hysteresis (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clear   (!analysis_en_i),
    .cnt     (cnt_q),
    .valid_o (valid)
  );

  assign ring_det_n_o = ~valid;

endmodule

// File: rtl/ring_qualifier_chk.sv
module ring_qualifier_chk #(
  parameter int CNT_W    = 6,
  parameter int QUAL_LVL = 48,
  parameter int DROP_LVL = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_up_i,
  input logic             tick_dn_i,
  input logic             analysis_en_i,
  input logic             cmp_i,
  input logic             ring_det_n_o,
  input logic [CNT_W-1:0] cnt
);

  localparam int CNT_MAX = (1 << CNT_W) - 1;

  AST_CLEAR_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !analysis_en_i |=> (ring_det_n_o && (cnt == '0))); // R7

  AST_NO_FALL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (analysis_en_i && cmp_i) |=> (cnt >= $past(cnt))); // R2

  AST_NO_RISE_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (analysis_en_i && !cmp_i) |=> (cnt <= $past(cnt))); // R3

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    analysis_en_i |=> ((int'(cnt) - int'($past(cnt)) <= 1) &&
                       (int'($past(cnt)) - int'(cnt) <= 1))); // R2

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (analysis_en_i && !tick_up_i && !tick_dn_i) |=> $stable(cnt)); // R8

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (analysis_en_i && cmp_i && (int'(cnt) == CNT_MAX)) |=> (int'(cnt) == CNT_MAX)); // R6

  AST_QUALIFY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ring_det_n_o) |-> (int'($past(cnt)) >= QUAL_LVL)); // R4

  AST_DROP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_det_n_o) |-> ((int'($past(cnt)) <= DROP_LVL) || !$past(analysis_en_i))); // R5

endmodule

bind ring_qualifier ring_qualifier_chk #(
  .CNT_W    (CNT_W),
  .QUAL_LVL (QUAL_LVL),
  .DROP_LVL (DROP_LVL)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tick_up_i     (tick_up_i),
  .tick_dn_i     (tick_dn_i),
  .analysis_en_i (analysis_en_i),
  .cmp_i         (cmp_i),
  .ring_det_n_o  (ring_det_n_o),
  .cnt           (cnt_q)
);

// File: tb/ring_qualifier_test.sv
module ring_qualifier_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic       cmp;
    logic [7:0] pulses;
    logic       exp_n;
  } vec_t;

  // Running count after each row: 47,48,33,32,47,63(sat),33,32,0(sat),47,48
  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'd47, 1'b1},  // R4 just below the qualify level
    '{1'b1, 8'd1,  1'b0},  // R4 reaches 48
    '{1'b0, 8'd15, 1'b0},  // R5 33 still qualified
    '{1'b0, 8'd1,  1'b1},  // R5 32 withdrawn
    '{1'b1, 8'd15, 1'b1},  // R5 climb inside the band stays high
    '{1'b1, 8'd20, 1'b0},  // R6 saturates at 63
    '{1'b0, 8'd30, 1'b0},  // R6 63-30=33 proves no wrap
    '{1'b0, 8'd1,  1'b1},  // R6 32
    '{1'b0, 8'd40, 1'b1},  // R6 floor at 0
    '{1'b1, 8'd47, 1'b1},  // R6 from exactly 0
    '{1'b1, 8'd1,  1'b0}   // R6 48
  };

  logic clk;
  logic rst_n;
  logic tick_up;
  logic tick_dn;
  logic en;
  logic cmp;
  logic ring_det_n;

  int checks;
  int errors;
  bit done;

  ring_qualifier uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .tick_up_i     (tick_up),
    .tick_dn_i     (tick_dn),
    .analysis_en_i (en),
    .cmp_i         (cmp),
    .ring_det_n_o  (ring_det_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s ring_det_n actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic up, input logic dn, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_up = up;
      tick_dn = dn;
      @(negedge clk);
      tick_up = 1'b0;
      tick_dn = 1'b0;
    end
  endtask

  // one extra edge lets the qualify register follow the count
  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    tick_up = 1'b0;
    tick_dn = 1'b0;
    en      = 1'b1;
    cmp     = 1'b1;
    repeat (3) @(negedge clk);
    check(ring_det_n, 1'b1, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(ring_det_n, 1'b1, "R1 after reset release");

    for (int v = 0; v < NVEC; v++) begin
      cmp = VECS[v].cmp;
      pulse(VECS[v].cmp, ~VECS[v].cmp, int'(VECS[v].pulses));
      settle();
      check(ring_det_n, VECS[v].exp_n, $sformatf("R4/R5/R6 vector %0d", v));
    end

    // R7: dropping the enable releases the output at once (count is 48)
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(ring_det_n, 1'b1, "R7 release on disable");
    cmp = 1'b1;
    pulse(1'b1, 1'b0, 60);
    settle();
    check(ring_det_n, 1'b1, "R7 ticks ignored while disabled");
    en = 1'b1;
    pulse(1'b1, 1'b0, 47);
    settle();
    check(ring_det_n, 1'b1, "R7 count restarted from 0");
    pulse(1'b1, 1'b0, 1);
    settle();
    check(ring_det_n, 1'b0, "R7 qualifies after 48 fresh counts");

    // R3: up ticks are ignored while the comparator is low (count 48)
    cmp = 1'b0;
    pulse(1'b1, 1'b0, 10);
    pulse(1'b0, 1'b1, 16);
    settle();
    check(ring_det_n, 1'b1, "R3 up ticks ignored, 48-16=32");

    // R2: down ticks are ignored while the comparator is high (count 32)
    cmp = 1'b1;
    pulse(1'b0, 1'b1, 10);
    // R8: no ticks for a long stretch, comparator toggling
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      cmp = i[0];
    end
    cmp = 1'b1;
    pulse(1'b1, 1'b0, 15);
    settle();
    check(ring_det_n, 1'b1, "R2 R8 count held at 47");
    pulse(1'b1, 1'b0, 1);
    settle();
    check(ring_det_n, 1'b0, "R2 R8 reaches 48");

    // R2 with both ticks in one cycle: only the up tick counts (48 -> 63)
    pulse(1'b1, 1'b1, 15);
    cmp = 1'b0;
    pulse(1'b0, 1'b1, 30);
    settle();
    check(ring_det_n, 1'b0, "R2 coincident ticks, 63-30=33");
    pulse(1'b0, 1'b1, 1);
    settle();
    check(ring_det_n, 1'b1, "R5 drops at 32");

    // R1: reset in the middle of activity
    cmp = 1'b1;
    pulse(1'b1, 1'b0, 20);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(ring_det_n, 1'b1, "R1 mid-run reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pulse(1'b1, 1'b0, 47);
    settle();
    check(ring_det_n, 1'b1, "R1 count zero after reset");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule